// File: doc/BRIEF.md
# Quadrature Tach Counter with Capture

This block turns the two phase signals of an incremental shaft encoder into a 16-bit position count that runs up or down with the direction of rotation. Every single-phase transition moves the count by one (4x resolution). A transition where both phases flip at once cannot be attributed to a direction, so it is flagged and not counted. Beside the count the block keeps the direction of the most recent count and an edge-gap timer. The timer advances on a 5 MHz enable, restarts at every count, and stops at its maximum. It therefore reports how long the shaft has gone without an edge, which a speed estimate at low speed needs.

A control loop reads the block through a snapshot. Position, direction and edge gap are copied together into capture registers when a loop strobe arrives. A configuration bit chooses which of two strobes, the fast inner-loop strobe or the slower application-loop strobe, triggers the copy. An optional index (marker) input latches the live position into its own register and raises a sticky flag that software acknowledges. The inputs are expected already synchronized to the block clock.

Top module: `tach_counter`

## Requirements
- R1: With the phase pair written {enc_a, enc_b}, the forward sequence is 00 -> 10 -> 11 -> 01 -> 00. A single-bit change along that sequence raises `pos` by one, and a single-bit change against it lowers `pos` by one. The new value shows after the clock edge that first samples the changed inputs. The phase history resets to 00.
- R2: When both phases change in the same sample, `pos` is left unchanged and `step_err` is high for exactly the following cycle.
- R3: `pos` wraps modulo 2^16: one step down from 0x0000 gives 0xFFFF, and one step up from 0xFFFF gives 0x0000.
- R4: `dir_up` becomes 1 after an up count and 0 after a down count. No sample without a count (including an error) changes it.
- R5: `gap_time` becomes 0 on every count. On any other edge it rises by one when `tick_en` is high and holds when `tick_en` is low.
- R6: `gap_time` stops at 0xFFFF and does not wrap.
- R7: With `ld_sel` = 0, `inner_ld` triggers a capture and `app_ld` has no effect. With `ld_sel` = 1 the roles are swapped.
- R8: A capture copies the `pos`, `dir_up` and `gap_time` values held just before the capturing edge into `cap_pos`, `cap_dir_up` and `cap_gap` together. A count on that same edge is not part of the snapshot.
- R9: A rising edge on `enc_mark` copies the `pos` value held before that edge into `mark_pos` and sets `mark_seen`. A marker held high does not latch again.
- R10: `mark_ack` clears `mark_seen`. A marker rising edge in the same cycle wins, and the flag stays set.
- R11: After reset every output is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enc_a | input | 1 | Encoder phase A, synchronized |
| enc_b | input | 1 | Encoder phase B, synchronized |
| enc_mark | input | 1 | Encoder index pulse, synchronized |
| tick_en | input | 1 | 5 MHz enable for the edge-gap timer |
| inner_ld | input | 1 | Inner-loop capture strobe |
| app_ld | input | 1 | Application-loop capture strobe |
| ld_sel | input | 1 | Strobe select: 0 inner, 1 application |
| mark_ack | input | 1 | Clears the sticky marker flag |
| pos | output | 16 | Live position count |
| dir_up | output | 1 | Direction of the last count, 1 = up |
| gap_time | output | 16 | Live ticks since the last count |
| step_err | output | 1 | One-cycle pulse on a double-phase change |
| cap_pos | output | 16 | Captured position |
| cap_dir_up | output | 1 | Captured direction |
| cap_gap | output | 16 | Captured edge gap |
| mark_pos | output | 16 | Position latched at the last marker |
| mark_seen | output | 1 | Sticky marker flag |

## Verification
The hardest state to reach is a saturated edge gap. It needs more than 65535 enabled ticks with no phase movement at all. The bench reaches it by parking the encoder and holding the tick enable high for a long stretch, then moves one step to confirm that the timer clears. A second case that is hard to hit by chance is a strobe that lands on the same edge as a count. The bench drives both in one cycle and checks that the snapshot holds the count from before the step. All sixteen pairs of previous and new phase codes are swept, and a bench model computed from phase indices tracks every output each cycle.

// File: rtl/tach_pkg.sv
package tach_pkg;

  typedef enum logic [1:0] {
    STEP_NONE = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DOWN = 2'd2,
    STEP_ERR  = 2'd3
  } step_e;

  // Classify one sample of the phase pair {a,b} against the previous one.
  // Forward order is 00 -> 10 -> 11 -> 01 -> 00.
  function automatic step_e quad_step(input logic [1:0] prev, input logic [1:0] cur);
    logic [1:0] diff;
    diff = prev ^ cur;
    if (diff == 2'b00) return STEP_NONE;
    if (diff == 2'b11) return STEP_ERR;
    // one phase moved: forward when new A differs from old B
    return (cur[1] ^ prev[0]) ? STEP_UP : STEP_DOWN;
  endfunction

endpackage

// File: rtl/tach_quad_dec.sv
module tach_quad_dec
  import tach_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic enc_a,
  input  logic enc_b,
  output logic up_evt,
  output logic dn_evt,
  output logic err_q
);

  logic [1:0] prev_q;
  logic [1:0] cur;
  step_e      step;

  assign cur    = {enc_a, enc_b};
  assign step   = quad_step(prev_q, cur);
  assign up_evt = (step == STEP_UP);
  assign dn_evt = (step == STEP_DOWN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 2'b00;
      err_q  <= 1'b0;
    end else begin
      prev_q <= cur;
      err_q  <= (step == STEP_ERR);
    end
  end

endmodule

// File: rtl/tach_position.sv
module tach_position #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         up_evt,
  input  logic         dn_evt,
  output logic [W-1:0] pos_q,
  output logic         dir_up_q
);

  localparam logic [W-1:0] ONE = W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q    <= '0;
      dir_up_q <= 1'b0;
    end else if (up_evt) begin
      pos_q    <= pos_q + ONE;
      dir_up_q <= 1'b1;
    end else if (dn_evt) begin
      pos_q    <= pos_q - ONE;
      dir_up_q <= 1'b0;
    end
  end

endmodule

// File: rtl/tach_gap_timer.sv
module tach_gap_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         restart,
  input  logic         tick_en,
  output logic [W-1:0] gap_q
);

  localparam logic [W-1:0] GAP_MAX = {W{1'b1}};

  function automatic logic [W-1:0] sat_inc(input logic [W-1:0] v);
    return (v == GAP_MAX) ? v : v + W'(1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        gap_q <= '0;
    else if (restart)  gap_q <= '0;
    else if (tick_en)  gap_q <= sat_inc(gap_q);
  end

endmodule

// File: rtl/tach_capture.sv
module tach_capture #(
  parameter int W = 33
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         fire,
  input  logic [W-1:0] live,
  output logic [W-1:0] snap_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    snap_q <= '0;
    else if (fire) snap_q <= live;
  end

endmodule

// File: rtl/tach_marker.sv
module tach_marker #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         mark_in,
  input  logic         ack,
  input  logic [W-1:0] pos,
  output logic [W-1:0] mark_pos_q,
  output logic         seen_q,
  output logic         rise
);

  logic mark_d;

  assign rise = mark_in & ~mark_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mark_d     <= 1'b0;
      mark_pos_q <= '0;
      seen_q     <= 1'b0;
    end else begin
      mark_d <= mark_in;
      if (rise) begin
        mark_pos_q <= pos;
        seen_q     <= 1'b1;
      end else if (ack) begin
        seen_q     <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/tach_counter.sv
module tach_counter #(
  parameter int POS_W     = 16,
  parameter int TIME_W    = 16,
  parameter bit MARKER_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enc_a,
  input  logic              enc_b,
  input  logic              enc_mark,
  input  logic              tick_en,
  input  logic              inner_ld,
  input  logic              app_ld,
  input  logic              ld_sel,
  input  logic              mark_ack,
  output logic [POS_W-1:0]  pos,
  output logic              dir_up,
  output logic [TIME_W-1:0] gap_time,
  output logic              step_err,
  output logic [POS_W-1:0]  cap_pos,
  output logic              cap_dir_up,
  output logic [TIME_W-1:0] cap_gap,
  output logic [POS_W-1:0]  mark_pos,
  output logic              mark_seen
);

  localparam int SNAP_W = POS_W + 1 + TIME_W;

  // named internal events, visible to the bound checker
  logic up_evt;
  logic dn_evt;
  logic count_evt;
  logic cap_fire;
  logic mark_rise;
  logic [SNAP_W-1:0] snap;

  assign count_evt = up_evt | dn_evt;
  assign cap_fire  = ld_sel ? app_ld : inner_ld;

  tach_quad_dec u_dec (
    .clk    (clk),
    .rst_n  (rst_n),
    .enc_a  (enc_a),
    .enc_b  (enc_b),
    .up_evt (up_evt),
    .dn_evt (dn_evt),
    .err_q  (step_err)
  );

  tach_position #(.W(POS_W)) u_pos (
    .clk      (clk),
    .rst_n    (rst_n),
    .up_evt   (up_evt),
    .dn_evt   (dn_evt),
    .pos_q    (pos),
    .dir_up_q (dir_up)
  );

  tach_gap_timer #(.W(TIME_W)) u_gap (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (count_evt),
    .tick_en (tick_en),
    .gap_q   (gap_time)
  );

  tach_capture #(.W(SNAP_W)) u_cap (
    .clk    (clk),
    .rst_n  (rst_n),
    .fire   (cap_fire),
    .live   ({pos, dir_up, gap_time}),
    .snap_q (snap)
  );

  assign {cap_pos, cap_dir_up, cap_gap} = snap;

  generate
    if (MARKER_EN) begin : g_mark
      tach_marker #(.W(POS_W)) u_mark (
        .clk        (clk),
        .rst_n      (rst_n),
        .mark_in    (enc_mark),
        .ack        (mark_ack),
        .pos        (pos),
        .mark_pos_q (mark_pos),
        .seen_q     (mark_seen),
        .rise       (mark_rise)
      );
    end else begin : g_nomark
      assign mark_pos  = '0;
      assign mark_seen = 1'b0;
      assign mark_rise = 1'b0;
    end
  endgenerate

endmodule

// File: rtl/tach_counter_chk.sv
module tach_counter_chk #(
  parameter int POS_W  = 16,
  parameter int TIME_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [POS_W-1:0]  pos,
  input logic              dir_up,
  input logic [TIME_W-1:0] gap_time,
  input logic              step_err,
  input logic [POS_W-1:0]  cap_pos,
  input logic              cap_dir_up,
  input logic [TIME_W-1:0] cap_gap,
  input logic [POS_W-1:0]  mark_pos,
  input logic              mark_seen,
  input logic              mark_ack,
  input logic              tick_en,
  input logic              inner_ld,
  input logic              app_ld,
  input logic              ld_sel,
  input logic              up_evt,
  input logic              count_evt,
  input logic              cap_fire,
  input logic              mark_rise
);

  localparam logic [TIME_W-1:0] GAP_MAX = {TIME_W{1'b1}};

  assert_unit_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pos) |-> (pos == POS_W'($past(pos) + 1'b1)) || (pos == POS_W'($past(pos) - 1'b1)));

  assert_err_no_move_R2: assert property (@(posedge clk) disable iff (!rst_n)
    step_err |-> $stable(pos));

  assert_dir_follows_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (count_evt && up_evt) |=> dir_up);

  assert_gap_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
    count_evt |=> (gap_time == '0));

  assert_gap_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!count_evt && tick_en && gap_time != GAP_MAX) |=> (gap_time == TIME_W'($past(gap_time) + 1'b1)));

  assert_gap_sat_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!count_evt && gap_time == GAP_MAX) |=> (gap_time == GAP_MAX));

  assert_unselected_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((ld_sel ? !app_ld : !inner_ld)) |=> ($stable(cap_pos) && $stable(cap_gap) && $stable(cap_dir_up)));

  assert_snapshot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cap_fire |=> (cap_pos == $past(pos)) && (cap_dir_up == $past(dir_up)) && (cap_gap == $past(gap_time)));

  assert_marker_latch_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mark_rise |=> (mark_seen && mark_pos == $past(pos)));

  assert_marker_ack_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mark_ack && !mark_rise) |=> !mark_seen);

endmodule

bind tach_counter tach_counter_chk #(.POS_W(POS_W), .TIME_W(TIME_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .pos        (pos),
  .dir_up     (dir_up),
  .gap_time   (gap_time),
  .step_err   (step_err),
  .cap_pos    (cap_pos),
  .cap_dir_up (cap_dir_up),
  .cap_gap    (cap_gap),
  .mark_pos   (mark_pos),
  .mark_seen  (mark_seen),
  .mark_ack   (mark_ack),
  .tick_en    (tick_en),
  .inner_ld   (inner_ld),
  .app_ld     (app_ld),
  .ld_sel     (ld_sel),
  .up_evt     (up_evt),
  .count_evt  (count_evt),
  .cap_fire   (cap_fire),
  .mark_rise  (mark_rise)
);

// File: tb/test_tach_counter.sv
module test_tach_counter;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] ab_d = 2'b00;
  logic mk_d = 1'b0, tk_d = 1'b0, il_d = 1'b0, al_d = 1'b0, sel_d = 1'b0, ak_d = 1'b0;

  logic [15:0] pos, gap_time, cap_pos, cap_gap, mark_pos;
  logic dir_up, step_err, cap_dir_up, mark_seen;

  int total = 0;
  int fails = 0;

  // bench model state
  logic [15:0] epos = 0, egap = 0, ecpos = 0, ecgap = 0, empos = 0;
  logic edir = 0, eerr = 0, ecdir = 0, eseen = 0, emk_d = 0;
  logic [1:0] eprev = 2'b00;
  int idx = 0;

  always #10 clk = ~clk;

  tach_counter i_tach_counter (
    .clk(clk), .rst_n(rst_n), .enc_a(ab_d[1]), .enc_b(ab_d[0]), .enc_mark(mk_d),
    .tick_en(tk_d), .inner_ld(il_d), .app_ld(al_d), .ld_sel(sel_d), .mark_ack(ak_d),
    .pos(pos), .dir_up(dir_up), .gap_time(gap_time), .step_err(step_err),
    .cap_pos(cap_pos), .cap_dir_up(cap_dir_up), .cap_gap(cap_gap),
    .mark_pos(mark_pos), .mark_seen(mark_seen)
  );

  function automatic logic [1:0] gray(input int i);
    case (i % 4)
      0: return 2'b00;
      1: return 2'b10;
      2: return 2'b11;
      default: return 2'b01;
    endcase
  endfunction

  function automatic int phase_idx(input logic [1:0] c);
    for (int i = 0; i < 4; i++) if (gray(i) == c) return i;
    return 0;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", total - fails, total);
  endtask

  // one clock: drive at negedge, update model, sample 1 ns after posedge
  task automatic cyc(input logic [1:0] ab, input logic tk, input logic il,
                     input logic al, input logic mk, input logic ak);
    int d;
    @(negedge clk);
    ab_d = ab; tk_d = tk; il_d = il; al_d = al; mk_d = mk; ak_d = ak;
    if (sel_d ? al : il) begin
      ecpos = epos; ecdir = edir; ecgap = egap;
    end
    if (mk && !emk_d) begin
      empos = epos; eseen = 1'b1;
    end else if (ak) eseen = 1'b0;
    emk_d = mk;
    d = (phase_idx(ab) - phase_idx(eprev) + 4) % 4;
    eerr = (d == 2);
    if (d == 1 || d == 3) begin
      epos = (d == 1) ? epos + 16'd1 : epos - 16'd1;
      edir = (d == 1);
      egap = 16'd0;
    end else if (tk && egap != 16'hFFFF) egap = egap + 16'd1;
    eprev = ab;
    @(posedge clk);
    #1;
    chk("R1 R3 pos", pos, epos);
    chk("R2 step_err", step_err, eerr);
    chk("R4 dir_up", dir_up, edir);
    chk("R5 R6 gap_time", gap_time, egap);
    chk("R7 R8 cap_pos", cap_pos, ecpos);
    chk("R7 R8 cap_dir_up", cap_dir_up, ecdir);
    chk("R7 R8 cap_gap", cap_gap, ecgap);
    chk("R9 mark_pos", mark_pos, empos);
    chk("R9 R10 mark_seen", mark_seen, eseen);
  endtask

  task automatic step(input bit up, input logic il, input logic al);
    idx = up ? (idx + 1) % 4 : (idx + 3) % 4;
    cyc(gray(idx), 1'b0, il, al, 1'b0, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    total++;
    $display("FAIL watchdog: actual hung, expected finished");
    summary();
    $finish;
  end

  initial begin
    logic [15:0] saved;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R11: reset state
    chk("R11 pos", pos, 0);
    chk("R11 dir_up", dir_up, 0);
    chk("R11 gap_time", gap_time, 0);
    chk("R11 step_err", step_err, 0);
    chk("R11 caps", {cap_pos, cap_dir_up, cap_gap}, 0);
    chk("R11 marker", {mark_pos, mark_seen}, 0);

    // R1 R2 R4: all sixteen previous/new phase pairs
    for (int p = 0; p < 4; p++)
      for (int q = 0; q < 4; q++) begin
        cyc(gray(p), 1'b1, (q == 2), 1'b0, 1'b0, 1'b0);
        cyc(gray(q), q[0], 1'b0, (q == 1), 1'b0, 1'b0);
      end

    // R2 explicit: both phases flip
    cyc(2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    saved = pos;
    cyc(2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R2 double change flag", step_err, 1);
    chk("R2 double change pos", pos, saved);
    cyc(2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R2 one-cycle pulse", step_err, 0);

    // R3: walk down through zero and back
    idx = phase_idx(2'b11);
    while (epos != 16'd0) step(1'b0, 1'b0, 1'b0);
    step(1'b0, 1'b0, 1'b0);
    chk("R3 wrap down", pos, 16'hFFFF);
    chk("R4 dir after down", dir_up, 0);
    step(1'b1, 1'b0, 1'b0);
    chk("R3 wrap up", pos, 16'h0000);

    // R7: inner strobe selected
    sel_d = 1'b0;
    step(1'b1, 1'b0, 1'b0);
    repeat (5) cyc(gray(idx), 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    saved = cap_gap;
    cyc(gray(idx), 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    chk("R7 app ignored when inner selected", cap_gap, saved);
    cyc(gray(idx), 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    chk("R7 inner capture gap", cap_gap, 5);
    chk("R7 inner capture pos", cap_pos, pos);

    // R7: application strobe selected
    sel_d = 1'b1;
    step(1'b0, 1'b0, 1'b0);
    repeat (3) cyc(gray(idx), 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    saved = cap_pos;
    cyc(gray(idx), 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    chk("R7 inner ignored when app selected", cap_pos, saved);
    cyc(gray(idx), 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    chk("R7 app capture gap", cap_gap, 3);
    chk("R7 app capture dir", cap_dir_up, 0);

    // R8: strobe on the same edge as a count
    saved = pos;
    step(1'b1, 1'b0, 1'b1);
    chk("R8 snapshot excludes same-edge count", cap_pos, saved);
    chk("R8 snapshot gap before restart", cap_gap, 3);
    chk("R8 live pos moved", pos, saved + 16'd1);

    // R9 R10: marker
    saved = pos;
    cyc(gray(idx), 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    chk("R9 marker latch", mark_pos, saved);
    chk("R9 marker flag", mark_seen, 1);
    idx = (idx + 1) % 4;
    cyc(gray(idx), 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    chk("R9 held marker no relatch", mark_pos, saved);
    cyc(gray(idx), 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    chk("R10 ack clears", mark_seen, 0);
    cyc(gray(idx), 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
    chk("R10 rise beats ack", mark_seen, 1);
    chk("R9 relatch after release", mark_pos, pos);
    cyc(gray(idx), 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);

    // R5 R6: saturate the edge-gap timer
    repeat (65540) cyc(gray(idx), 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R6 gap saturates", gap_time, 16'hFFFF);
    cyc(gray(idx), 1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
    chk("R6 captured saturated gap", cap_gap, 16'hFFFF);
    step(1'b1, 1'b0, 1'b0);
    chk("R5 count restarts gap", gap_time, 0);
    cyc(gray(idx), 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R5 gap ticks after restart", gap_time, 1);
    cyc(gray(idx), 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R5 gap holds without tick", gap_time, 1);

    summary();
    $finish;
  end

endmodule